// File: doc/BRIEF.md
# Quadrature Position Counter with Byte Control

This block keeps a 32-bit position count from a pair of quadrature signals. A controller drives it through an 8-bit control byte and reads an 8-bit status byte back, together with a 32-bit preset word that goes in and a 32-bit capture word that comes out. The controller can load the count from the preset word and sees an acknowledge when it does. It can arm a one-shot capture of the count on a reference-mark pulse. It can have the count cleared by a separate zeroing input. It can also watch two error flags. One flag is sticky and reports that the edge rate was too high. The other reports that the input signal has gone.

A control byte with its top bit set puts the byte pair into register-access mode. In that mode the status byte echoes the direction bit and the register number, the capture word reads as zero, and no control action takes effect. Counting goes on in both modes.

Top module: `quad_pos_unit`

## Requirements
- R1: After 2-flop synchronisation, every single-bit change of the {A,B} state moves the count by one. The state order 00→10→11→01→00 counts up and the reverse order counts down. A change of both bits at once is ignored, and the count wraps modulo 2^32.
- R2: In process mode (ctrl bit 7 = 0), a rising edge of ctrl bit 2 loads the count from preset_i and sets status bit 2. Status bit 2 clears once ctrl bit 2 is low, and holding ctrl bit 2 high causes no further loads.
- R3: While ctrl bit 0 is high and status bit 0 is low, the first synchronised rising edge of ref_mark_i copies the count into data_o and sets status bit 0. Further marks leave data_o unchanged.
- R4: Driving ctrl bit 0 low clears status bit 0 on the next clock. Raising ctrl bit 0 again then arms a new capture.
- R5: A synchronised rising edge of zero_in_i clears the count only when ctrl bit 5 and ctrl bit 0 are both high. Otherwise the edge has no effect.
- R6: Status bit 3 is set when a counted edge comes fewer than freq_limit_i clocks after the previous counted edge. A limit of 0 turns the check off. Once set, the bit stays set whatever the edge rate.
- R7: While ctrl bit 6 is high in process mode, status bit 3 is held clear and no rate check takes place.
- R8: In process mode, status bit 5 equals the synchronised level of sig_ok_ni (high means no signal). Status bit 6 equals bit 5, and status bits 7, 4 and 1 read 0.
- R9: With ctrl bit 7 = 1, status_o = {1, ctrl_i[6:0]} and data_o = 0. No control bit acts in this mode, including a rising edge of bit 2 and a high bit 6.
- R10: After reset the count, data_o and all status flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| quad_a_i | input | 1 | Quadrature channel A, asynchronous |
| quad_b_i | input | 1 | Quadrature channel B, asynchronous |
| ref_mark_i | input | 1 | Reference-mark pulse, asynchronous |
| zero_in_i | input | 1 | Zeroing input, asynchronous |
| sig_ok_ni | input | 1 | Signal present, active low, asynchronous |
| ctrl_i | input | 8 | Control byte |
| preset_i | input | 32 | Preset word for count loading |
| freq_limit_i | input | 16 | Minimum clocks between counted edges |
| status_o | output | 8 | Status byte |
| data_o | output | 32 | Captured count (0 in register mode) |

## Verification
The bench pulses a second reference mark while the latch is still armed. A latch that is not one-shot would overwrite the value held in data_o. It holds the preset bit high while counting, so a level-triggered load would snap the count back to the preset. It sends zeroing pulses with the arm bit low, and it raises bit 2 and bit 6 in register mode; a design that decodes these bits regardless of enables or mode would clear the count, reload it or wipe the error. The rate-error checks cover fast edges while the reset bit is held, slow edges after an error, and an error that sets again after release, which catches a flag that is not sticky or a check that still runs while suppressed.

// File: rtl/qpu_pkg.sv
package qpu_pkg;
  // control byte bit positions
  localparam int CB_REG  = 7;
  localparam int CB_FCLR = 6;
  localparam int CB_ZEN  = 5;
  localparam int CB_SET  = 2;
  localparam int CB_ARM  = 0;
  // status byte bit positions
  localparam int SB_REG   = 7;
  localparam int SB_ERR   = 6;
  localparam int SB_NOSIG = 5;
  localparam int SB_FRQ   = 3;
  localparam int SB_ACK   = 2;
  localparam int SB_VAL   = 0;
  // synchroniser lane map
  localparam int SY_A    = 0;
  localparam int SY_B    = 1;
  localparam int SY_REF  = 2;
  localparam int SY_ZERO = 3;
  localparam int SY_SIG  = 4;
  localparam int SY_W    = 5;
endpackage

// File: rtl/qpu_sync.sv
module qpu_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
    end else begin
      pipe[0] <= d_i;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q_o = pipe[STAGES-1];
endmodule

// File: rtl/qpu_quad.sv
module qpu_quad (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic a_i,
  input  logic b_i,
  output logic step_o,
  output logic up_o
);
  logic [1:0] ab_q;
  logic [1:0] chg;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ab_q <= 2'b00;
    else         ab_q <= {a_i, b_i};
  end

  assign chg    = {a_i, b_i} ^ ab_q;
  // exactly one channel moved; double changes are dropped
  assign step_o = (chg == 2'b10) || (chg == 2'b01);
  assign up_o   = chg[1] ? (a_i ^ b_i) : ~(a_i ^ b_i);
endmodule

// File: rtl/qpu_freq.sv
module qpu_freq #(
  parameter int LIM_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic             hold_i,
  input  logic [LIM_W-1:0] limit_i,
  output logic             err_o
);
  logic [LIM_W-1:0] gap_q;

  // gap_q = clocks since last counted edge, saturating
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             gap_q <= '1;
    else if (step_i)         gap_q <= LIM_W'(1);
    else if (gap_q != '1)    gap_q <= gap_q + LIM_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          err_o <= 1'b0;
    else if (hold_i)                      err_o <= 1'b0;
    else if (step_i && gap_q < limit_i)   err_o <= 1'b1;
  end
endmodule

// File: rtl/qpu_core.sv
module qpu_core #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic             up_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] preset_i,
  input  logic             zero_i,
  input  logic             arm_i,
  input  logic             disarm_i,
  input  logic             mark_i,
  output logic [CNT_W-1:0] cap_o,
  output logic             valid_o
);
  logic [CNT_W-1:0] cnt_q;

  // priority: preset load, then zeroing, then stepping
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (load_i)  cnt_q <= preset_i;
    else if (zero_i)  cnt_q <= '0;
    else if (step_i)  cnt_q <= up_i ? cnt_q + CNT_W'(1) : cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_o   <= '0;
      valid_o <= 1'b0;
    end else if (disarm_i) begin
      valid_o <= 1'b0;
    end else if (arm_i && !valid_o && mark_i) begin
      cap_o   <= cnt_q;
      valid_o <= 1'b1;
    end
  end
endmodule

// File: rtl/quad_pos_unit.sv
module quad_pos_unit
  import qpu_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int LIM_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             quad_a_i,
  input  logic             quad_b_i,
  input  logic             ref_mark_i,
  input  logic             zero_in_i,
  input  logic             sig_ok_ni,
  input  logic [7:0]       ctrl_i,
  input  logic [CNT_W-1:0] preset_i,
  input  logic [LIM_W-1:0] freq_limit_i,
  output logic [7:0]       status_o,
  output logic [CNT_W-1:0] data_o
);
  logic [SY_W-1:0]  sy;
  logic             step, up, frq_err, valid;
  logic             ref_q, zero_q, set_q, ack_q;
  logic             proc, load, zero, arm, disarm, hold;
  logic [CNT_W-1:0] cap;

  qpu_sync #(.W(SY_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sig_ok_ni, zero_in_i, ref_mark_i, quad_b_i, quad_a_i}),
    .q_o   (sy)
  );

  qpu_quad u_quad (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .a_i   (sy[SY_A]),
    .b_i   (sy[SY_B]),
    .step_o(step),
    .up_o  (up)
  );

  // edge history for marks and the preset request
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_q  <= 1'b0;
      zero_q <= 1'b0;
      set_q  <= 1'b0;
    end else begin
      ref_q  <= sy[SY_REF];
      zero_q <= sy[SY_ZERO];
      set_q  <= ctrl_i[CB_SET];
    end
  end

  assign proc   = ~ctrl_i[CB_REG];
  assign load   = proc & ctrl_i[CB_SET] & ~set_q;
  assign zero   = proc & ctrl_i[CB_ZEN] & ctrl_i[CB_ARM] & sy[SY_ZERO] & ~zero_q;
  assign arm    = proc & ctrl_i[CB_ARM];
  assign disarm = proc & ~ctrl_i[CB_ARM];
  assign hold   = proc & ctrl_i[CB_FCLR];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        ack_q <= 1'b0;
    else if (proc && !ctrl_i[CB_SET])   ack_q <= 1'b0;
    else if (load)                      ack_q <= 1'b1;
  end

  qpu_core #(.CNT_W(CNT_W)) u_core (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .step_i  (step),
    .up_i    (up),
    .load_i  (load),
    .preset_i(preset_i),
    .zero_i  (zero),
    .arm_i   (arm),
    .disarm_i(disarm),
    .mark_i  (sy[SY_REF] & ~ref_q),
    .cap_o   (cap),
    .valid_o (valid)
  );

  qpu_freq #(.LIM_W(LIM_W)) u_freq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (step),
    .hold_i (hold),
    .limit_i(freq_limit_i),
    .err_o  (frq_err)
  );

  always_comb begin
    status_o = '0;
    if (!proc) begin
      status_o = {1'b1, ctrl_i[6:0]};
    end else begin
      status_o[SB_ERR]   = sy[SY_SIG];
      status_o[SB_NOSIG] = sy[SY_SIG];
      status_o[SB_FRQ]   = frq_err;
      status_o[SB_ACK]   = ack_q;
      status_o[SB_VAL]   = valid;
    end
  end

  assign data_o = proc ? cap : '0;
endmodule

// File: rtl/qpu_chk.sv
module qpu_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [7:0]       ctrl_i,
  input logic [7:0]       status_o,
  input logic [CNT_W-1:0] data_o
);
  a_r9_reg_echo: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_i[7] |-> (status_o == {1'b1, ctrl_i[6:0]} && data_o == '0));

  a_r8_err_nosig: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_i[7] |-> (status_o[6] == status_o[5] && !status_o[7] && !status_o[4] && !status_o[1]));

  a_r3_latch_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_i[7] && status_o[0]) |=> (ctrl_i[7] || !status_o[0] || $stable(data_o)));

  a_r4_disarm_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_i[7] && !ctrl_i[0]) |=> (ctrl_i[7] || !status_o[0]));

  a_r2_ack_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_i[7] && !ctrl_i[2]) |=> (ctrl_i[7] || !status_o[2]));

  a_r6_frq_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_i[7] && !ctrl_i[6] && status_o[3]) |=> (ctrl_i[7] || status_o[3]));

  a_r7_frq_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_i[7] && ctrl_i[6]) |=> (ctrl_i[7] || !status_o[3]));
endmodule

bind quad_pos_unit qpu_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .ctrl_i  (ctrl_i),
  .status_o(status_o),
  .data_o  (data_o)
);

// File: tb/sim_quad_pos_unit.sv
module sim_quad_pos_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        qa = 1'b0, qb = 1'b0, refm = 1'b0, zin = 1'b0, sig = 1'b0;
  logic [7:0]  ctrl = 8'h00;
  logic [31:0] preset = '0;
  logic [15:0] flim = '0;
  logic [7:0]  st;
  logic [31:0] dat;

  int n_run = 0, n_fail = 0, qi = 0;
  logic [31:0] exp_cnt = '0;
  logic [31:0] v;

  always #5 clk = ~clk;

  quad_pos_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .quad_a_i(qa), .quad_b_i(qb),
    .ref_mark_i(refm), .zero_in_i(zin), .sig_ok_ni(sig), .ctrl_i(ctrl),
    .preset_i(preset), .freq_limit_i(flim), .status_o(st), .data_o(dat)
  );

  // {ctrl[7:0], sig_ok_n, expected status[7:0]}
  localparam logic [16:0] VECS [6] = '{
    {8'h00, 1'b0, 8'h00},
    {8'h00, 1'b1, 8'h60},
    {8'h80, 1'b1, 8'h80},
    {8'hC5, 1'b0, 8'hC5},
    {8'hBF, 1'b1, 8'hBF},
    {8'h00, 1'b0, 8'h00}
  };

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic move(int n, bit up, int gap);
    for (int i = 0; i < n; i++) begin
      qi = up ? (qi + 1) % 4 : (qi + 3) % 4;
      case (qi)
        0: {qa, qb} = 2'b00;
        1: {qa, qb} = 2'b10;
        2: {qa, qb} = 2'b11;
        default: {qa, qb} = 2'b01;
      endcase
      exp_cnt = up ? exp_cnt + 1 : exp_cnt - 1;
      tick(gap);
    end
    tick(4);
  endtask

  task automatic pulse_ref();
    refm = 1'b1; tick(2); refm = 1'b0; tick(5);
  endtask

  task automatic pulse_zero();
    zin = 1'b1; tick(2); zin = 1'b0; tick(5);
  endtask

  task automatic capture(output logic [31:0] val);
    ctrl[0] = 1'b0; tick(3);
    ctrl[0] = 1'b1; tick(1);
    pulse_ref();
    val = dat;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(2);
    chk(st == 8'h00, "R10 status", {24'd0, st}, 32'h0);
    chk(dat == 32'h0, "R10 data", dat, 32'h0);

    // status vectors: process mode flags and register echo
    for (int i = 0; i < 6; i++) begin
      ctrl = VECS[i][16:9];
      sig  = VECS[i][8];
      tick(4);
      chk(st == VECS[i][7:0], ctrl[7] ? "R9 echo" : "R8 flags", {24'd0, st}, {24'd0, VECS[i][7:0]});
      if (ctrl[7]) chk(dat == 32'h0, "R9 data zero", dat, 32'h0);
    end

    // R1 count up, R3 capture
    move(10, 1'b1, 4);
    capture(v);
    chk(v == exp_cnt, "R1 up count", v, exp_cnt);
    chk(st[0] == 1'b1, "R3 valid set", {31'd0, st[0]}, 32'h1);

    // R3 one-shot: second mark ignored
    move(5, 1'b1, 4);
    pulse_ref();
    chk(dat == 32'd10, "R3 one-shot", dat, 32'd10);

    // R4 handshake
    ctrl[0] = 1'b0; tick(2);
    chk(st[0] == 1'b0, "R4 valid clear", {31'd0, st[0]}, 32'h0);
    capture(v);
    chk(v == exp_cnt, "R4 rearm capture", v, exp_cnt);

    // R1 down and wrap
    move(18, 1'b0, 4);
    capture(v);
    chk(v == 32'hFFFF_FFFD, "R1 down wrap", v, 32'hFFFF_FFFD);

    // R2 preset
    preset = 32'h1234_5678;
    ctrl[2] = 1'b1; tick(2);
    chk(st[2] == 1'b1, "R2 ack set", {31'd0, st[2]}, 32'h1);
    exp_cnt = preset;
    capture(v);
    chk(v == 32'h1234_5678, "R2 preset load", v, 32'h1234_5678);
    move(2, 1'b1, 4);
    capture(v);
    chk(v == 32'h1234_567A, "R2 no reload while held", v, 32'h1234_567A);
    ctrl[2] = 1'b0; tick(2);
    chk(st[2] == 1'b0, "R2 ack clear", {31'd0, st[2]}, 32'h0);

    // R5 zeroing needs arm
    ctrl[5] = 1'b1; ctrl[0] = 1'b0; tick(2);
    pulse_zero();
    capture(v);
    chk(v == exp_cnt, "R5 zero ignored unarmed", v, exp_cnt);
    pulse_zero();
    exp_cnt = '0;
    capture(v);
    chk(v == 32'h0, "R5 zero on edge", v, 32'h0);
    ctrl[5] = 1'b0;

    // R9 control bits inert in register mode
    preset = 32'hDEAD_BEEF;
    ctrl = 8'h80; tick(2);
    ctrl = 8'h84; tick(3);
    chk(st == 8'h84, "R9 echo dir/num", {24'd0, st}, 32'h84);
    chk(dat == 32'h0, "R9 data zero", dat, 32'h0);
    ctrl = 8'h00; tick(3);
    chk(st[2] == 1'b0, "R9 no ack", {31'd0, st[2]}, 32'h0);
    capture(v);
    chk(v == exp_cnt, "R9 no load", v, exp_cnt);

    // R6 frequency error
    flim = 16'd10;
    move(3, 1'b1, 20);
    chk(st[3] == 1'b0, "R6 slow ok", {31'd0, st[3]}, 32'h0);
    move(2, 1'b1, 3);
    chk(st[3] == 1'b1, "R6 fast sets", {31'd0, st[3]}, 32'h1);
    move(3, 1'b1, 20);
    chk(st[3] == 1'b1, "R6 sticky", {31'd0, st[3]}, 32'h1);
    ctrl = 8'hC0; tick(3);
    ctrl = 8'h00; tick(2);
    chk(st[3] == 1'b1, "R9 bit6 inert", {31'd0, st[3]}, 32'h1);

    // R7 clear and suppress
    ctrl[6] = 1'b1; tick(2);
    chk(st[3] == 1'b0, "R7 clear", {31'd0, st[3]}, 32'h0);
    move(4, 1'b1, 3);
    chk(st[3] == 1'b0, "R7 suppressed", {31'd0, st[3]}, 32'h0);
    ctrl[6] = 1'b0; tick(2);
    chk(st[3] == 1'b0, "R7 stays clear", {31'd0, st[3]}, 32'h0);
    move(2, 1'b1, 3);
    chk(st[3] == 1'b1, "R6 sets again", {31'd0, st[3]}, 32'h1);

    // R6 limit 0 disables
    ctrl[6] = 1'b1; tick(2); ctrl[6] = 1'b0;
    flim = 16'd0;
    move(4, 1'b0, 2);
    chk(st[3] == 1'b0, "R6 limit zero", {31'd0, st[3]}, 32'h0);
    capture(v);
    chk(v == exp_cnt, "R1 final count", v, exp_cnt);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule